// File: doc/BRIEF.md
# Pipelined 8b/10b Line Encoder

This block turns one byte per cycle into a ten-bit line symbol with bounded running disparity, suitable for a serial link that needs DC balance and frequent transitions. Each input beat carries an eight-bit value, a control flag that picks between the 256 data symbols and the 12 control symbols, and a valid strobe. The result leaves a fixed three-register pipeline together with a valid flag, an error flag and the running disparity after that symbol.

The low five bits of the byte are mapped to a six-bit sub-block and the high three bits to a four-bit sub-block; control bytes go through a separate twelve-entry table whose words hold a ten-bit code plus a balance bit that tells the last stage whether the symbol flips running disparity. The disparity register lives in the last stage only, so back-to-back symbols need no stall. A control request for a byte that is not a legal control code raises the error flag and sends the comma-bearing K28.5 symbol instead.

Top module: `line_enc8b10b`

## Requirements
- R1: With the control flag low, bits [4:0] (x) are coded to the six-bit sub-block placed on out_sym[9:4] (first transmitted bit at out_sym[9]) and bits [7:5] (y) to the four-bit sub-block on out_sym[3:0], following the standard 8b/10b data code for the current running disparity.
- R2: With the control flag high, the twelve legal bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD, 0xFE produce K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7; the positive-disparity form is the bitwise complement of the negative form.
- R3: An input beat with in_valid high appears with out_valid high exactly three clock cycles later, in input order, with no gaps added or removed.
- R4: Running disparity (out_rd, 1 = positive) is negative after reset; every emitted symbol holds four, five or six ones; a symbol with six ones is sent only from negative disparity and one with four only from positive; out_rd flips exactly when the symbol is unbalanced, so the running ones-minus-zeros count stays within 0 to +2 of its start.
- R5: The serialized stream (bit 9 of each symbol first) never holds more than five equal bits in a row.
- R6: For y = 7, the alternate four-bit code (0111 at negative, 1000 at positive disparity after the six-bit part) replaces the primary one when x is 17, 18 or 20 at negative disparity, or 11, 13 or 14 at positive disparity.
- R7: A control request for a byte outside the twelve legal ones sets out_err with that symbol, emits K28.5 (0011111010 at negative, 1100000101 at positive disparity) and updates disparity as K28.5 does; out_err is low on every other cycle.
- R8: Idle input cycles give out_valid low three cycles later, leave out_rd and out_sym unchanged and keep out_err low.
- R9: A synchronous active-high reset clears out_valid, out_err, out_sym (to zero), the pipeline contents, and sets out_rd negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ctrl | input | 1 | 1 = control symbol requested, 0 = data |
| in_byte | input | 8 | Byte to encode |
| out_valid | output | 1 | Output symbol present |
| out_sym | output | 10 | Line symbol, bit 9 transmitted first |
| out_err | output | 1 | Illegal control byte replaced by K28.5 |
| out_rd | output | 1 | Running disparity after the last symbol, 1 = positive |

## Verification
The hardest case to reach from the ports is the alternate D.x.7 code, because it needs a particular x together with a particular disparity that depends on everything sent before. The stimulus reads the reference model's disparity at the moment it drives a beat and, when the polarity is wrong, first inserts K28.5 (which always flips disparity) so that each of the six qualifying x values is sent under both polarities. Every legal control code is likewise sent under both polarities, illegal control bytes are mixed in, and a long random stream with idle gaps checks disparity, run length and idle hold across arbitrary neighbours.

// File: rtl/le_enc_pkg.sv
package le_enc_pkg;

    localparam int DATA_W   = 8;
    localparam int X_W      = 5;
    localparam int Y_W      = DATA_W - X_W;
    localparam int SUB6_W   = 6;
    localparam int SUB4_W   = 4;
    localparam int SYM_W    = SUB6_W + SUB4_W;
    localparam int KCNT     = 12;
    localparam int KENT_W   = SYM_W + 1;
    localparam int COMMA_IX = 5;

    // Data sub-block lookups, negative-disparity form plus steering flags
    typedef struct packed {
        logic [SUB6_W-1:0] c6;
        logic              flip6;   // complement at positive disparity
        logic              unbal6;  // sub-block flips disparity
        logic [SUB4_W-1:0] c4;
        logic              flip4;
        logic              unbal4;
        logic              y7;
        logic              alt_n;   // alternate candidate at negative disparity
        logic              alt_p;   // alternate candidate at positive disparity
    } dlut_t;

    typedef struct packed {
        logic [SYM_W-1:0] code;     // negative-disparity form
        logic             bal;      // symbol is perfectly balanced
        logic             legal;
    } klut_t;

    typedef struct packed {
        logic  valid;
        logic  is_k;
        dlut_t d;
        klut_t k;
    } s2_t;

    function automatic logic [SUB6_W-1:0] six_b(input logic [X_W-1:0] x);
        case (x)
            5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [SUB4_W-1:0] four_b(input logic [Y_W-1:0] y);
        case (y)
            3'd0: return 4'b1011;  3'd1: return 4'b1001;
            3'd2: return 4'b0101;  3'd3: return 4'b1100;
            3'd4: return 4'b1101;  3'd5: return 4'b1010;
            3'd6: return 4'b0110;  default: return 4'b1110;
        endcase
    endfunction

    // Byte value of control entry i
    function automatic logic [DATA_W-1:0] k_value(input int i);
        case (i)
            8:       return 8'hF7;
            9:       return 8'hFB;
            10:      return 8'hFD;
            11:      return 8'hFE;
            default: return {3'(i), 5'd28};
        endcase
    endfunction

    // {balanced, negative-disparity code} of control entry i
    function automatic logic [KENT_W-1:0] k_word(input int i);
        case (i)
            0:       return 11'b1_001111_0100;
            1:       return 11'b0_001111_1001;
            2:       return 11'b0_001111_0101;
            3:       return 11'b0_001111_0011;
            4:       return 11'b1_001111_0010;
            5:       return 11'b0_001111_1010;
            6:       return 11'b0_001111_0110;
            7:       return 11'b1_001111_1000;
            8:       return 11'b1_111010_1000;
            9:       return 11'b1_110110_1000;
            10:      return 11'b1_101110_1000;
            default: return 11'b1_011110_1000;
        endcase
    endfunction

endpackage

// File: rtl/le_data_lut.sv
module le_data_lut
    import le_enc_pkg::*;
(
    input  logic [DATA_W-1:0] byte_in,
    output dlut_t             d_o
);
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;

    assign x = byte_in[X_W-1:0];
    assign y = byte_in[DATA_W-1:X_W];

    always_comb begin
        d_o.c6     = six_b(x);
        d_o.unbal6 = ($countones(d_o.c6) != SUB6_W / 2);
        d_o.flip6  = d_o.unbal6 || (x == 5'd7);
        d_o.c4     = four_b(y);
        d_o.unbal4 = ($countones(d_o.c4) != SUB4_W / 2);
        d_o.flip4  = d_o.unbal4 || (y == 3'd3);
        d_o.y7     = (y == 3'd7);
        d_o.alt_n  = (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
        d_o.alt_p  = (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
    end
endmodule

// File: rtl/le_ctrl_lut.sv
module le_ctrl_lut
    import le_enc_pkg::*;
(
    input  logic [DATA_W-1:0] byte_in,
    output klut_t             k_o
);
    logic [KCNT-1:0]   hit;
    logic [KENT_W-1:0] word;

    for (genvar gi = 0; gi < KCNT; gi++) begin : g_entry
        assign hit[gi] = (byte_in == k_value(gi));
    end

    always_comb begin
        word = k_word(COMMA_IX);
        for (int i = 0; i < KCNT; i++) begin
            if (hit[i]) word = k_word(i);
        end
        k_o.code  = word[SYM_W-1:0];
        k_o.bal   = word[KENT_W-1];
        k_o.legal = |hit;
    end
endmodule

// File: rtl/le_disp_stage.sv
module le_disp_stage
    import le_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  s2_t              s2,
    output logic             sym_valid,
    output logic [SYM_W-1:0] sym,
    output logic             sym_err,
    output logic             rd
);
    logic [SUB6_W-1:0] c6;
    logic [SUB4_W-1:0] c4_base, c4;
    logic              rd6, use_alt, d_rd, k_rd, nxt_rd;
    logic [SYM_W-1:0]  d_sym, k_sym, nxt_sym;

    always_comb begin
        c6      = (rd && s2.d.flip6) ? ~s2.d.c6 : s2.d.c6;
        rd6     = rd ^ s2.d.unbal6;
        use_alt = s2.d.y7 && ((!rd6 && s2.d.alt_n) || (rd6 && s2.d.alt_p));
        c4_base = use_alt ? 4'b0111 : s2.d.c4;
        c4      = (rd6 && s2.d.flip4) ? ~c4_base : c4_base;
        d_sym   = {c6, c4};
        d_rd    = rd6 ^ s2.d.unbal4;
        k_sym   = rd ? ~s2.k.code : s2.k.code;
        k_rd    = s2.k.bal ? rd : ~rd;
        nxt_sym = s2.is_k ? k_sym : d_sym;
        nxt_rd  = s2.is_k ? k_rd  : d_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid <= 1'b0;
            sym_err   <= 1'b0;
            sym       <= '0;
            rd        <= 1'b0;
        end else begin
            sym_valid <= s2.valid;
            sym_err   <= s2.valid && s2.is_k && !s2.k.legal;
            if (s2.valid) begin
                sym <= nxt_sym;
                rd  <= nxt_rd;
            end
        end
    end

    AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> ($countones(sym) >= 4 && $countones(sym) <= 6)); // R4
    AST_RD_FLIP: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> ((rd != $past(rd)) == ($countones(sym) != 5))); // R4
    AST_UNBAL_SIGN: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && $countones(sym) != 5) |-> (($countones(sym) > 5) == !$past(rd))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> ($stable(rd) && $stable(sym))); // R8
    AST_ERR_QUAL: assert property (@(posedge clk) disable iff (rst)
        sym_err |-> sym_valid); // R7
    AST_ERR_COMMA: assert property (@(posedge clk) disable iff (rst)
        sym_err |-> (sym == 10'b0011111010 || sym == 10'b1100000101)); // R7
endmodule

// File: rtl/line_enc8b10b.sv
module line_enc8b10b
    import le_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctrl,
    input  logic [DATA_W-1:0] in_byte,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_sym,
    output logic              out_err,
    output logic              out_rd
);
    logic              s1_valid, s1_k;
    logic [DATA_W-1:0] s1_byte;
    dlut_t             d_lut;
    klut_t             k_lut;
    s2_t               s2_q;

    // Stage 1: capture the beat
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_k     <= 1'b0;
            s1_byte  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_k     <= in_ctrl;
            s1_byte  <= in_byte;
        end
    end

    le_data_lut u_data_lut (.byte_in(s1_byte), .d_o(d_lut));
    le_ctrl_lut u_ctrl_lut (.byte_in(s1_byte), .k_o(k_lut));

    // Stage 2: hold disparity-independent lookups
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.valid <= s1_valid;
            s2_q.is_k  <= s1_k;
            s2_q.d     <= d_lut;
            s2_q.k     <= k_lut;
        end
    end

    // Stage 3: disparity selection and output register
    le_disp_stage u_disp (
        .clk       (clk),
        .rst       (rst),
        .s2        (s2_q),
        .sym_valid (out_valid),
        .sym       (out_sym),
        .sym_err   (out_err),
        .rd        (out_rd)
    );

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid); // R3
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid); // R8
    AST_DATA_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ctrl) |-> ##3 !out_err); // R7
endmodule

// File: tb/line_enc8b10b_bench.sv
`timescale 1ns/1ps
module line_enc8b10b_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ctrl = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_err, out_rd;
    logic [9:0] out_sym;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    line_enc8b10b u_line_enc8b10b (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_byte(in_byte), .out_valid(out_valid), .out_sym(out_sym),
        .out_err(out_err), .out_rd(out_rd)
    );

    typedef struct {
        bit       v;
        bit [9:0] sym;
        bit       err;
        bit       rd;
        string    tag;
    } exp_t;

    exp_t     q[$];
    bit       m_rd = 1'b0;
    bit [9:0] m_last = '0;
    bit       s_prev = 1'b0;
    int       s_run = 0;
    int       s_cum = 0;

    function automatic bit [5:0] m_6b(input bit [4:0] x);
        bit [5:0] t[32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                            6'b110101, 6'b101001, 6'b011001, 6'b111000,
                            6'b111001, 6'b100101, 6'b010101, 6'b110100,
                            6'b001101, 6'b101100, 6'b011100, 6'b010111,
                            6'b011011, 6'b100011, 6'b010011, 6'b110010,
                            6'b001011, 6'b101010, 6'b011010, 6'b111010,
                            6'b110011, 6'b100110, 6'b010110, 6'b110110,
                            6'b001110, 6'b101110, 6'b011110, 6'b101011};
        return t[x];
    endfunction

    function automatic bit [3:0] m_4b(input bit [2:0] y);
        bit [3:0] t[8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                           4'b1101, 4'b1010, 4'b0110, 4'b1110};
        return t[y];
    endfunction

    function automatic bit m_legal_k(input bit [7:0] b);
        return (b[4:0] == 5'd28) || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
    endfunction

    function automatic bit [9:0] m_encode(input bit [7:0] bi, input bit k,
                                          input bit rd, output string tag);
        bit [7:0] b = bi;
        bit [5:0] s6;
        bit [3:0] s4;
        bit [9:0] c;
        bit       r6;
        bit [4:0] x;
        bit [2:0] y;
        tag = "R1";
        if (k && !m_legal_k(b)) begin b = 8'hBC; tag = "R7"; end
        else if (k) tag = "R2";
        x = b[4:0];
        y = b[7:5];
        if (k) begin
            s6 = (x == 5'd28) ? 6'b001111 : m_6b(x);
            s4 = (y == 3'd7) ? 4'b1000 : m_4b(y);
            if (y != 3'd7 && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
            c = {s6, s4};
            return rd ? ~c : c;
        end
        s6 = m_6b(x);
        if (rd && ($countones(s6) != 3 || s6 == 6'b111000)) s6 = ~s6;
        r6 = ($countones(s6) == 3) ? rd : ($countones(s6) > 3);
        s4 = m_4b(y);
        if (y == 3'd7 && ((!r6 && (x == 17 || x == 18 || x == 20)) ||
                          (r6 && (x == 11 || x == 13 || x == 14)))) begin
            s4 = 4'b0111;
            tag = "R6";
        end
        if (r6 && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
        return {s6, s4};
    endfunction

    task automatic check_bit(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_front();
        exp_t e;
        e = q.pop_front();
        check_bit(e.v ? "R3" : "R8", "out_valid", int'(out_valid), int'(e.v));
        check_bit(e.v ? e.tag : "R8", "out_sym", int'(out_sym), int'(e.sym));
        check_bit(e.v ? "R4" : "R8", "out_rd", int'(out_rd), int'(e.rd));
        check_bit("R7", "out_err", int'(out_err), int'(e.err));
        if (out_valid) begin
            bit bad_run = 1'b0;
            for (int i = 9; i >= 0; i--) begin
                if (s_run > 0 && out_sym[i] == s_prev) s_run++;
                else s_run = 1;
                s_prev = out_sym[i];
                if (s_run > 5) bad_run = 1'b1;
            end
            check_bit("R5", "run over 5", int'(bad_run), 0);
            s_cum += 2 * $countones(out_sym) - 10;
            check_bit("R4", "running sum", s_cum, out_rd ? 2 : 0);
        end
    endtask

    task automatic step(input bit v, input bit k, input bit [7:0] b);
        exp_t e;
        string t;
        @(negedge clk);
        compare_front();
        in_valid = v;
        in_ctrl  = k;
        in_byte  = b;
        e.v   = v;
        e.err = v && k && !m_legal_k(b);
        e.tag = "R8";
        if (v) begin
            m_last = m_encode(b, k, m_rd, t);
            e.tag  = t;
            if ($countones(m_last) != 5) m_rd = ($countones(m_last) > 5);
        end
        e.sym = m_last;
        e.rd  = m_rd;
        q.push_back(e);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        exp_t r;
        bit [7:0] klist[12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
        bit [4:0] alts[6] = '{5'd11, 5'd13, 5'd14, 5'd17, 5'd18, 5'd20};
        bit [7:0] bad_k[5] = '{8'h00, 8'h1B, 8'hFF, 8'h3D, 8'h47};
        repeat (4) @(negedge clk);
        // R9: outputs in reset
        check_bit("R9", "reset out_valid", int'(out_valid), 0);
        check_bit("R9", "reset out_err", int'(out_err), 0);
        check_bit("R9", "reset out_sym", int'(out_sym), 0);
        check_bit("R9", "reset out_rd", int'(out_rd), 0);
        rst = 1'b0;
        r.v = 0; r.sym = 0; r.err = 0; r.rd = 0; r.tag = "R9";
        repeat (3) q.push_back(r);

        // R1: every data byte back to back
        for (int i = 0; i < 256; i++) step(1, 0, 8'(i));
        // R2: every control code under both disparities
        foreach (klist[i]) begin
            for (int pol = 0; pol < 2; pol++) begin
                if (m_rd != pol[0]) step(1, 1, 8'hBC);
                step(1, 1, klist[i]);
            end
        end
        // R6: alternate D.x.7 under both disparities
        foreach (alts[i]) begin
            for (int pol = 0; pol < 2; pol++) begin
                if (m_rd != pol[0]) step(1, 1, 8'hBC);
                step(1, 0, {3'd7, alts[i]});
            end
        end
        // R7: illegal control bytes under both disparities
        foreach (bad_k[i]) begin
            step(1, 1, bad_k[i]);
            step(1, 1, bad_k[i]);
            step(1, 0, 8'h03);
        end
        // R8: idle gaps between symbols
        for (int i = 0; i < 20; i++) begin
            step(1, 0, 8'(i * 37));
            repeat (i % 4) step(0, 1, 8'hFF);
        end
        // Random mixed stream
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom % 10) < 7;
            bit k = ($urandom % 8) == 0;
            bit [7:0] b = 8'($urandom);
            if (k && ($urandom % 5) != 0) b = klist[$urandom % 12];
            step(v, k, b);
        end
        repeat (4) step(0, 0, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule